// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Software Injection

This block gathers up to 32 interrupt causes into one interrupt line for a host processor. Single-cycle event pulses from hardware sources set sticky bits in a status word. Software can also raise any status bit through a write-only injection register. Each status bit is gated by a mask word whose sense is inverted: a mask bit at 0 lets its cause through, and a mask bit at 1 blocks it.

The host reaches the three words through a plain register port that reads and writes one word per cycle. It clears a handled cause by writing a 1 to that bit of the status word. Several causes have a fixed meaning. Bit 27 marks a finished transfer on the capture side. Bit 20 marks a finished transfer on the playback side. Bit 18 reports a rejected transfer descriptor chain. Bits 31 down to 28 carry capture start, end of stream, ancillary-line capture and input-module reset. Bits 25, 24, 22, 21 and 19 carry the remaining playback-side events.

All of these signals are control and status lines, so the port has no valid/ready handshake. A write is taken in the cycle its strobe is high. A read always completes and returns its data one cycle later, so the host is never stalled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the status word reads 0, the mask word reads 32'hFFFF_FFFF and `irq_o` is low.
- R2: A high bit on `evt_i` at a hardware-sourced position (bits 31..27, 25, 24 and 22..18) sets the matching status bit at the next clock edge.
- R3: `evt_i` bits 26, 23 and 17..0 have no hardware source. Pulses on them leave the status word unchanged.
- R4: A write to word index 1 (injection) sets every status bit written as 1 and leaves bits written as 0 unchanged. A read of index 1 returns 0.
- R5: Status bits are sticky. A write to word index 0 clears each bit written as 1 and leaves the other bits unchanged.
- R6: When a hardware event and a status clear reach the same bit in the same cycle, the bit ends up set.
- R7: A write to word index 2 replaces the mask word, and a read of index 2 returns it.
- R8: `irq_o` is high in the cycle after a cycle in which any status bit is 1 while its mask bit is 0. Otherwise it is low.
- R9: `rd_data` shows the word that was read, one cycle after `rd_en`. It is 0 after a cycle with no read and after a read of the unused index 3. A write to index 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Hardware event pulses, one per cause bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 2 | Word index: 0 status, 1 injection, 2 mask, 3 unused |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The assertions check four things on every cycle: that hardware events on sourced bits always land even when a clear hits the same bit, that no status bit falls without a clear write, that the mask comes out of reset all ones, and that `irq_o` follows the gated status one cycle later. The bench scenarios are needed to show other behaviour. These cover the unsourced event bits being ignored, injection and clear touching only the bits written as 1, the injection word and the unused index reading back as 0, and mask readback. A cycle-accurate model in the bench compares both outputs under directed and pseudo-random traffic.

// File: rtl/irq_aggregator_pkg.sv
package irq_aggregator_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_INJECT = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_NONE   = 2'd3
  } word_sel_e;

  // Causes with a hardware source: 31..27, 25, 24, 22..18
  localparam logic [31:0] HW_SOURCED = 32'hFB7C_0000;
endpackage

// File: rtl/irq_status_bit.sv
module irq_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic q
);
  // set terms dominate the clear term
  always_ff @(posedge clk) begin
    if (!rst_n)               q <= 1'b0;
    else if (hw_set || sw_set) q <= 1'b1;
    else if (sw_clr)          q <= 1'b0;
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_aggregator_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [W-1:0]     status,
  input  logic [W-1:0]     mask,
  output logic [W-1:0]     clr_vec,
  output logic [W-1:0]     inj_vec,
  output logic             mask_we,
  output logic [W-1:0]     rd_data
);
  word_sel_e sel;
  logic [W-1:0] rd_mux;

  always_comb begin
    sel = word_sel_e'(reg_idx);
    clr_vec = (wr_en && sel == SEL_STATUS) ? wr_data : '0;
    inj_vec = (wr_en && sel == SEL_INJECT) ? wr_data : '0;
    mask_we = wr_en && (sel == SEL_MASK);
    case (sel)
      SEL_STATUS: rd_mux = status;
      SEL_MASK:   rd_mux = mask;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(status & ~mask);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_aggregator_pkg::*;
#(
  parameter int          W      = 32,
  parameter int          IDX_W  = 2,
  parameter logic [W-1:0] HW_SRC = HW_SOURCED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     evt_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  output logic             irq_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] clr_vec;
  logic [W-1:0] inj_vec;
  logic         mask_we;

  irq_reg_port #(.W(W), .IDX_W(IDX_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .reg_idx (reg_idx),
    .wr_data (wr_data),
    .status  (status_q),
    .mask    (mask_q),
    .clr_vec (clr_vec),
    .inj_vec (inj_vec),
    .mask_we (mask_we),
    .rd_data (rd_data)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (HW_SRC[b]) begin : g_src
      irq_status_bit u_bit (
        .clk(clk), .rst_n(rst_n), .hw_set(evt_i[b]),
        .sw_set(inj_vec[b]), .sw_clr(clr_vec[b]), .q(status_q[b])
      );
    end else begin : g_nosrc
      logic unused_evt;
      assign unused_evt = evt_i[b];
      irq_status_bit u_bit (
        .clk(clk), .rst_n(rst_n), .hw_set(1'b0),
        .sw_set(inj_vec[b]), .sw_clr(clr_vec[b]), .q(status_q[b])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= wr_data;
  end

  irq_line #(.W(W)) u_line (
    .clk(clk), .rst_n(rst_n), .status(status_q), .mask(mask_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int          W      = 32,
  parameter int          IDX_W  = 2,
  parameter logic [W-1:0] HW_SRC = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     evt_i,
  input logic             wr_en,
  input logic [IDX_W-1:0] reg_idx,
  input logic [W-1:0]     status_q,
  input logic [W-1:0]     mask_q,
  input logic             irq_o
);
  logic [W-1:0] src_evt;
  logic         clr_wr;
  assign src_evt = evt_i & HW_SRC;
  assign clr_wr  = wr_en && (reg_idx == '0);

  // R1: mask leaves reset all ones
  assert_mask_reset_R1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (mask_q == '1));

  // R2, R6: sourced events always land, even against a clear
  assert_event_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status_q & $past(src_evt)) == $past(src_evt)));

  // R5: no bit falls without a status write
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr_wr)) |-> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: line follows gated status one cycle later
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == $past(|(status_q & ~mask_q))));
endmodule

bind irq_aggregator irq_aggregator_chk #(.W(W), .IDX_W(IDX_W), .HW_SRC(HW_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .reg_idx(reg_idx),
  .status_q(status_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam logic [31:0] SRC = 32'hFB7C_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int cycles = 0;

  // reference state
  logic [31:0] m_status = '0, m_mask = '1, m_rd = '0;
  logic        m_irq = 1'b0;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got hung run expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic compare(string tag);
    checks++;
    if (irq_o !== m_irq) begin
      fails++;
      $display("FAIL %s irq_o got %b expected %b", tag, irq_o, m_irq);
    end
    checks++;
    if (rd_data !== m_rd) begin
      fails++;
      $display("FAIL %s rd_data got %h expected %h", tag, rd_data, m_rd);
    end
  endtask

  // one cycle: drive, clock, advance model, compare at negedge
  task automatic step(input logic [31:0] e, input logic w, input logic r,
                      input logic [1:0] idx, input logic [31:0] d, input string tag);
    logic [31:0] nxt;
    evt_i = e; wr_en = w; rd_en = r; reg_idx = idx; wr_data = d;
    @(posedge clk);
    m_irq = |(m_status & ~m_mask);
    m_rd  = !r ? 32'h0 : (idx == 2'd0) ? m_status : (idx == 2'd2) ? m_mask : 32'h0;
    nxt = m_status;
    if (w && idx == 2'd0) nxt = nxt & ~d;
    if (w && idx == 2'd1) nxt = nxt | d;
    nxt = nxt | (e & SRC);
    m_status = nxt;
    if (w && idx == 2'd2) m_mask = d;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input logic [1:0] idx, input string tag);
    step('0, 1'b0, 1'b1, idx, '0, tag);
  endtask

  initial begin
    logic [31:0] lf = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    rd(2'd0, "R1");
    rd(2'd2, "R1");

    step(32'h0800_0000, 0, 0, 0, 0, "R2");       // capture-side transfer done
    rd(2'd0, "R2");
    step(32'h0014_0000, 0, 0, 0, 0, "R2");       // bits 20 and 18
    rd(2'd0, "R2");

    step(32'h0483_FFFF, 0, 0, 0, 0, "R3");       // 26, 23, 17..0
    rd(2'd0, "R3");

    step('0, 1, 0, 2'd1, 32'h0400_0005, "R4");
    rd(2'd0, "R4");
    rd(2'd1, "R4");

    step('0, 1, 0, 2'd2, ~32'h0800_0000, "R7");
    rd(2'd2, "R7");
    step('0, 0, 0, 0, 0, "R8");
    step('0, 0, 0, 0, 0, "R8");

    step('0, 1, 0, 2'd0, 32'h0800_0000, "R5");
    step('0, 0, 0, 0, 0, "R5");
    rd(2'd0, "R5");

    step('0, 1, 0, 2'd2, ~32'h0010_0000, "R7");
    step(32'h0010_0000, 1, 0, 2'd0, 32'h0010_0000, "R6");
    step('0, 0, 0, 0, 0, "R6");
    rd(2'd0, "R6");

    step('0, 1, 0, 2'd3, 32'hFFFF_FFFF, "R9");
    rd(2'd3, "R9");
    rd(2'd0, "R9");
    rd(2'd2, "R9");

    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step((lf[3:0] == 0) ? lf : 32'h0, lf[5], lf[6], lf[8:7],
           {lf[15:0], lf[31:16]}, "R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule